// File: doc/BRIEF.md
# Radio Transceiver Power and Packet Sequencer

This block steers a 2.4 GHz radio through its power states and through one transmit or receive packet at a time. After reset is released it steps through a power-on state and a register-load state into idle. From idle, software-owned control bits pick the next action. A transmit request runs a start state, a programmable synthesizer settle wait, a programmable power-amplifier ramp wait, and the data phase. A receive request runs a start state, a programmable settle wait before sync search, and the data phase. A sleep request parks the radio until the serial-bus select line is pulled low.

The sequencer drives the enables of the analog and data-path sections and a packet flag for the host. It also exposes its state as a 4-bit code. Settle waits are counted in microseconds. The microseconds come from a prescaler on the 12 MHz system clock, and that prescaler restarts whenever a wait begins, so each wait lasts an exact number of clock cycles.

Top module: `radio_seq_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state becomes OFF and every enable and the packet flag are low. After `rst_n` is high, the state steps OFF, PWRON, INIT, IDLE on consecutive edges.
- R2: In IDLE with `tx_en` high, the next state is TX_START, whatever `rx_en` and `sleep_req` are. TX_START lasts one cycle and is followed by TX_SYNC.
- R3: TX_SYNC lasts `tx_sync_us`×12 cycles, or a single cycle when `tx_sync_us` is 0. The value is sampled in the TX_START cycle.
- R4: TX_PAON follows TX_SYNC. It lasts `tx_pa_us`×12 cycles, or one cycle when that value is 0, and is followed by TX_DATA.
- R5: TX_DATA is left for TX_DONE on any edge where `tx_done` is high or `tx_en` is low. TX_DONE lasts one cycle and returns to IDLE.
- R6: In IDLE with `tx_en` low and `rx_en` high, the state goes to RX_START for one cycle and then to RX_SYNC. RX_SYNC lasts `rx_sync_us`×12 cycles (one cycle for 0) and is followed by RX_DATA.
- R7: RX_DATA is left for RX_DONE when `rx_done` is high or `rx_en` is low. RX_DONE lasts one cycle and returns to IDLE.
- R8: IDLE goes to SLEEP only when both enables are low, `sleep_req` is high and `ss_n` is high. SLEEP is held while `ss_n` stays high.
- R9: In SLEEP, a low `ss_n` moves the state to WAKE, and WAKE returns to IDLE after one cycle.
- R10: `synth_en` is high in every state except OFF, SLEEP and IDLE.
- R11: `pa_en` is high exactly in TX_PAON, TX_DATA and TX_DONE.
- R12: `pkt_flag` is high exactly in TX_DATA, TX_DONE, RX_DATA and RX_DONE. `tx_path_en` is high only in TX_DATA and `rx_path_en` only in RX_DATA.
- R13: `state_code` encodes OFF=0, PWRON=1, INIT=2, IDLE=3, SLEEP=4, WAKE=5, TX_START=6, TX_SYNC=7, TX_PAON=8, TX_DATA=9, TX_DONE=10, RX_START=11, RX_SYNC=12, RX_DATA=13, RX_DONE=14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 12 MHz system clock |
| rst_n | input | 1 | Synchronous active-low reset; low holds the radio off |
| tx_en | input | 1 | Transmit request/continue control bit |
| rx_en | input | 1 | Receive request/continue control bit |
| sleep_req | input | 1 | Sleep request control bit |
| ss_n | input | 1 | Serial-bus select, active low |
| tx_done | input | 1 | Packet-complete pulse from the framer |
| rx_done | input | 1 | Packet-complete pulse from the deframer |
| tx_sync_us | input | 8 | Transmit synthesizer settle time, microseconds |
| tx_pa_us | input | 8 | Power-amplifier ramp time, microseconds |
| rx_sync_us | input | 8 | Receive settle time before sync search, microseconds |
| synth_en | output | 1 | Synthesizer enable |
| pa_en | output | 1 | Power-amplifier enable |
| tx_path_en | output | 1 | Transmit data path enable |
| rx_path_en | output | 1 | Receive data path enable |
| pkt_flag | output | 1 | Packet in progress flag |
| state_code | output | 4 | Current state code |

## Verification
The hardest case to reach is a wait that ends on the exact cycle the microsecond count expires. Two other cases are also hard: a wait of zero, and an abort that arrives in the first data cycle. Each happens only when a request, a delay value and a done pulse line up with the prescaler phase. The stimulus keeps the delay values small, mostly 0 to 3, and re-randomizes them often so that zero-length and one-microsecond waits come up many times. Done pulses and enable drops land at random offsets, and a directed 255-microsecond transmit wait covers the widest count.

// File: rtl/radio_seq_pkg.sv
// Shared parameters and state encoding for the radio sequencer.
// Assumes a single synchronous clock domain; the state code values are visible at the top ports.
package radio_seq_pkg;
    localparam int DLY_W   = 8;
    localparam int STATE_W = 4;

    typedef enum logic [STATE_W-1:0] {
        ST_OFF      = 4'd0,
        ST_PWRON    = 4'd1,
        ST_INIT     = 4'd2,
        ST_IDLE     = 4'd3,
        ST_SLEEP    = 4'd4,
        ST_WAKE     = 4'd5,
        ST_TX_START = 4'd6,
        ST_TX_SYNC  = 4'd7,
        ST_TX_PAON  = 4'd8,
        ST_TX_DATA  = 4'd9,
        ST_TX_DONE  = 4'd10,
        ST_RX_START = 4'd11,
        ST_RX_SYNC  = 4'd12,
        ST_RX_DATA  = 4'd13,
        ST_RX_DONE  = 4'd14
    } seq_state_e;
endpackage

// File: rtl/rsq_us_prescaler.sv
// Microsecond tick generator: divides the system clock by CLK_PER_US.
// Assumes CLK_PER_US >= 1. The restart input realigns the phase so a new wait starts a fresh microsecond.
module rsq_us_prescaler #(
    parameter int CLK_PER_US = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_PER_US - 1);

    logic [PW-1:0] phase;

    // Phase counter: wraps at LAST, cleared on reset or restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (restart || phase == LAST) begin
            phase <= '0;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign tick = (phase == LAST);
endmodule

// File: rtl/rsq_settle_timer.sv
// Microsecond countdown for the settle waits.
// A load in cycle t makes the wait begin in cycle t+1. The wait is expired in its last cycle:
// after N*CLK_PER_US cycles, or at once when N is 0. It assumes that the prescaler restarts with the load.
module rsq_settle_timer #(
    parameter int DLY_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] load_val,
    input  logic             tick,
    output logic             expired
);
    logic [DLY_W-1:0] remain;

    // Remaining-microsecond register: loaded at the start of a wait, counted down on ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (tick && remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0) || (remain == DLY_W'(1) && tick);
endmodule

// File: rtl/rsq_state_fsm.sv
// Sequencing state machine for power-up, sleep, transmit and receive.
// Assumes the control inputs are synchronous to clk. Transmit has priority over receive, and receive over sleep.
module rsq_state_fsm
    import radio_seq_pkg::*;
#(
    parameter int DW = DLY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_en,
    input  logic          rx_en,
    input  logic          sleep_req,
    input  logic          ss_n,
    input  logic          tx_done,
    input  logic          rx_done,
    input  logic [DW-1:0] tx_sync_us,
    input  logic [DW-1:0] tx_pa_us,
    input  logic [DW-1:0] rx_sync_us,
    input  logic          wait_expired,
    output logic          wait_load,
    output logic [DW-1:0] wait_val,
    output seq_state_e    state
);
    seq_state_e nxt;

    // State register: synchronous reset forces the radio off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_OFF;
        end else begin
            state <= nxt;
        end
    end

    // Next-state selection.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:      nxt = ST_PWRON;
            ST_PWRON:    nxt = ST_INIT;
            ST_INIT:     nxt = ST_IDLE;
            ST_IDLE: begin
                if (tx_en)                  nxt = ST_TX_START;
                else if (rx_en)             nxt = ST_RX_START;
                else if (sleep_req && ss_n) nxt = ST_SLEEP;
            end
            ST_SLEEP:    if (!ss_n) nxt = ST_WAKE;
            ST_WAKE:     nxt = ST_IDLE;
            ST_TX_START: nxt = ST_TX_SYNC;
            ST_TX_SYNC:  if (wait_expired) nxt = ST_TX_PAON;
            ST_TX_PAON:  if (wait_expired) nxt = ST_TX_DATA;
            ST_TX_DATA:  if (tx_done || !tx_en) nxt = ST_TX_DONE;
            ST_TX_DONE:  nxt = ST_IDLE;
            ST_RX_START: nxt = ST_RX_SYNC;
            ST_RX_SYNC:  if (wait_expired) nxt = ST_RX_DATA;
            ST_RX_DATA:  if (rx_done || !rx_en) nxt = ST_RX_DONE;
            ST_RX_DONE:  nxt = ST_IDLE;
            default:     nxt = ST_OFF;
        endcase
    end

    // Wait loading: arms the settle timer on the cycle before each wait state.
    always_comb begin
        wait_load = 1'b0;
        wait_val  = '0;
        if (state == ST_TX_START) begin
            wait_load = 1'b1;
            wait_val  = tx_sync_us;
        end else if (state == ST_TX_SYNC && wait_expired) begin
            wait_load = 1'b1;
            wait_val  = tx_pa_us;
        end else if (state == ST_RX_START) begin
            wait_load = 1'b1;
            wait_val  = rx_sync_us;
        end
    end
endmodule

// File: rtl/rsq_out_decode.sv
// Decodes the sequencer state into section enables and the packet flag.
// It holds no state of its own, so the outputs follow the state register in the same cycle.
module rsq_out_decode
    import radio_seq_pkg::*;
(
    input  seq_state_e         state,
    output logic               synth_en,
    output logic               pa_en,
    output logic               tx_path_en,
    output logic               rx_path_en,
    output logic               pkt_flag,
    output logic [STATE_W-1:0] state_code
);
    // Enable decode per state.
    always_comb begin
        synth_en   = !(state inside {ST_OFF, ST_SLEEP, ST_IDLE});
        pa_en      = state inside {ST_TX_PAON, ST_TX_DATA, ST_TX_DONE};
        tx_path_en = (state == ST_TX_DATA);
        rx_path_en = (state == ST_RX_DATA);
        pkt_flag   = state inside {ST_TX_DATA, ST_TX_DONE, ST_RX_DATA, ST_RX_DONE};
        state_code = state;
    end
endmodule

// File: rtl/radio_seq_ctrl.sv
// Top of the radio power and packet sequencer.
// It connects the prescaler, the settle timer, the state machine and the output decode.
// Assumes a 12 MHz clk by default (CLK_PER_US) and control inputs that are synchronous to it.
module radio_seq_ctrl
    import radio_seq_pkg::*;
#(
    parameter int CLK_PER_US = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_en,
    input  logic               rx_en,
    input  logic               sleep_req,
    input  logic               ss_n,
    input  logic               tx_done,
    input  logic               rx_done,
    input  logic [DLY_W-1:0]   tx_sync_us,
    input  logic [DLY_W-1:0]   tx_pa_us,
    input  logic [DLY_W-1:0]   rx_sync_us,
    output logic               synth_en,
    output logic               pa_en,
    output logic               tx_path_en,
    output logic               rx_path_en,
    output logic               pkt_flag,
    output logic [STATE_W-1:0] state_code
);
    logic             us_tick;
    logic             wait_load;
    logic [DLY_W-1:0] wait_val;
    logic             wait_expired;
    seq_state_e       state;

    rsq_us_prescaler #(.CLK_PER_US(CLK_PER_US)) u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (wait_load),
        .tick    (us_tick)
    );

    rsq_settle_timer #(.DLY_W(DLY_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (wait_val),
        .tick     (us_tick),
        .expired  (wait_expired)
    );

    rsq_state_fsm #(.DW(DLY_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_en        (tx_en),
        .rx_en        (rx_en),
        .sleep_req    (sleep_req),
        .ss_n         (ss_n),
        .tx_done      (tx_done),
        .rx_done      (rx_done),
        .tx_sync_us   (tx_sync_us),
        .tx_pa_us     (tx_pa_us),
        .rx_sync_us   (rx_sync_us),
        .wait_expired (wait_expired),
        .wait_load    (wait_load),
        .wait_val     (wait_val),
        .state        (state)
    );

    rsq_out_decode u_dec (
        .state      (state),
        .synth_en   (synth_en),
        .pa_en      (pa_en),
        .tx_path_en (tx_path_en),
        .rx_path_en (rx_path_en),
        .pkt_flag   (pkt_flag),
        .state_code (state_code)
    );
endmodule

// File: rtl/rsq_checker.sv
// Property checker for radio_seq_ctrl, attached through bind. It observes the top-level ports only.
module rsq_checker
    import radio_seq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               tx_en,
    input logic               rx_en,
    input logic               ss_n,
    input logic               synth_en,
    input logic               pa_en,
    input logic               tx_path_en,
    input logic               rx_path_en,
    input logic               pkt_flag,
    input logic [STATE_W-1:0] state_code
);
    a_r1_off_to_pwron: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == ST_OFF |=> state_code == ST_PWRON);
    a_r1_init_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == ST_INIT |=> state_code == ST_IDLE);
    a_r2_tx_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_IDLE && tx_en) |=> state_code == ST_TX_START);
    a_r5_tx_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == ST_TX_DONE |=> state_code == ST_IDLE);
    a_r6_rx_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_IDLE && !tx_en && rx_en) |=> state_code == ST_RX_START);
    a_r7_rx_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        state_code == ST_RX_DONE |=> state_code == ST_IDLE);
    a_r8_sleep_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_SLEEP && ss_n) |=> state_code == ST_SLEEP);
    a_r9_wake: assert property (@(posedge clk) disable iff (!rst_n)
        (state_code == ST_SLEEP && !ss_n) |=> state_code == ST_WAKE);
    a_r11_pa_needs_synth: assert property (@(posedge clk) disable iff (!rst_n)
        pa_en |-> synth_en);
    a_r12_one_path: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_path_en, rx_path_en}));
    a_r12_path_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_path_en || rx_path_en) |-> pkt_flag);
endmodule

bind radio_seq_ctrl rsq_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tx_en      (tx_en),
    .rx_en      (rx_en),
    .ss_n       (ss_n),
    .synth_en   (synth_en),
    .pa_en      (pa_en),
    .tx_path_en (tx_path_en),
    .rx_path_en (rx_path_en),
    .pkt_flag   (pkt_flag),
    .state_code (state_code)
);

// File: tb/tb_radio_seq_ctrl.sv
`timescale 1ns/1ps
module tb_radio_seq_ctrl;
    localparam int PER_US = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_en = 0, rx_en = 0, sleep_req = 0, ss_n = 1, tx_done = 0, rx_done = 0;
    logic [7:0] tx_sync_us = 0, tx_pa_us = 0, rx_sync_us = 0;
    logic synth_en, pa_en, tx_path_en, rx_path_en, pkt_flag;
    logic [3:0] state_code;

    int n_vec = 0;
    int n_bad = 0;
    int m_st = 0;   // expected state code
    int m_rem = 0;  // expected cycles left in the current wait

    always #4 clk = ~clk;

    radio_seq_ctrl dut (.*);

    // Requirement tag blamed for a state mismatch, from the expected state.
    function automatic string tag_of(int s);
        case (s)
            0, 1, 2: return "R1";
            6:       return "R2";
            7:       return "R3";
            8:       return "R4";
            9, 10:   return "R5";
            11, 12:  return "R6";
            13, 14:  return "R7";
            4:       return "R8";
            5:       return "R9";
            default: return "R13";
        endcase
    endfunction

    function automatic int wait_len(logic [7:0] us);
        return (us == 0) ? 1 : int'(us) * PER_US;
    endfunction

    // Expected next state from the requirements, given the current inputs.
    task automatic model_step();
        int nx;
        nx = m_st;
        if (!rst_n) begin
            nx = 0;
        end else begin
            case (m_st)
                0: nx = 1;
                1: nx = 2;
                2: nx = 3;
                3: if (tx_en) nx = 6; else if (rx_en) nx = 11; else if (sleep_req && ss_n) nx = 4;
                4: if (!ss_n) nx = 5;
                5: nx = 3;
                6: begin nx = 7; m_rem = wait_len(tx_sync_us); end
                7: if (m_rem == 1) begin nx = 8; m_rem = wait_len(tx_pa_us); end else m_rem--;
                8: if (m_rem == 1) nx = 9; else m_rem--;
                9: if (tx_done || !tx_en) nx = 10;
                10: nx = 3;
                11: begin nx = 12; m_rem = wait_len(rx_sync_us); end
                12: if (m_rem == 1) nx = 13; else m_rem--;
                13: if (rx_done || !rx_en) nx = 14;
                14: nx = 3;
                default: nx = 0;
            endcase
        end
        m_st = nx;
    endtask

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    // Compare all outputs against the expected state.
    task automatic check_outputs();
        chk(tag_of(m_st), int'(state_code), m_st);
        chk("R10 synth_en", int'(synth_en), (m_st == 0 || m_st == 3 || m_st == 4) ? 0 : 1);
        chk("R11 pa_en", int'(pa_en), (m_st >= 8 && m_st <= 10) ? 1 : 0);
        chk("R12 pkt_flag", int'(pkt_flag), (m_st == 9 || m_st == 10 || m_st == 13 || m_st == 14) ? 1 : 0);
        chk("R12 tx_path_en", int'(tx_path_en), (m_st == 9) ? 1 : 0);
        chk("R12 rx_path_en", int'(rx_path_en), (m_st == 13) ? 1 : 0);
    endtask

    // One clock: inputs are already set at a negedge; advance the model and compare at the next negedge.
    task automatic cycle();
        model_step();
        @(negedge clk);
        check_outputs();
    endtask

    task automatic run_n(int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        rst_n = 0;
        cycle();   // R1: reset state, all enables low
        cycle();
        rst_n = 1;
        run_n(4);  // R1: power-up sequence into idle

        // R2 and R3: both enables set with the widest sync wait; R4 with a zero PA wait.
        tx_sync_us = 8'd255; tx_pa_us = 8'd0;
        tx_en = 1; rx_en = 1;
        run_n(255 * PER_US + 10);
        tx_done = 1; cycle(); tx_done = 0;   // R5: done pulse ends data
        tx_en = 0;
        run_n(4);                            // R6: receive follows once transmit is dropped
        rx_sync_us = 8'd1;
        run_n(20);
        rx_en = 0; run_n(4);                 // R7: enable drop ends receive
        sleep_req = 1; ss_n = 1; run_n(10);  // R8: sleep entry and hold
        ss_n = 0; run_n(4);                  // R9: wake
        sleep_req = 0; ss_n = 1;

        // Constrained random phase.
        for (int c = 0; c < 40000; c++) begin
            if ($urandom_range(39, 0) == 0) tx_en = ~tx_en;
            if ($urandom_range(39, 0) == 0) rx_en = ~rx_en;
            if ($urandom_range(24, 0) == 0) sleep_req = ~sleep_req;
            if ($urandom_range(19, 0) == 0) ss_n = ~ss_n;
            tx_done = ($urandom_range(29, 0) == 0);
            rx_done = ($urandom_range(29, 0) == 0);
            if ($urandom_range(63, 0) == 0) begin
                tx_sync_us = 8'($urandom_range(3, 0));
                tx_pa_us   = 8'($urandom_range(3, 0));
                rx_sync_us = 8'($urandom_range(3, 0));
            end
            rst_n = ($urandom_range(2999, 0) != 0);
            cycle();
        end
        rst_n = 1;
        run_n(5);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog expired at %0t: actual running expected finished", $time);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule